// File: doc/BRIEF.md
# Four-Digit Multiplexed Decimal Display Counter

This block keeps a free-running decimal count from 0000 to 9999 and shows it on a four-digit seven-segment display that is driven by time multiplexing. The count is held as a chain of BCD digits (units, tens, hundreds, thousands). A carry from one digit steps the next one. All logic runs on a single 50 MHz system clock with a synchronous reset.

Two tick dividers derive single-cycle enable pulses from the clock. A slow tick advances the units digit twice per second. A faster tick moves the display scanner to the next digit 500 times per second, which gives each digit a refresh rate of 125 Hz. The scanner selects one digit at a time through active-low select lines and drives eight shared segment lines. The segment lines carry that digit's pattern, and the decimal point is held off. The divide ratios come from clock and rate parameters, so a test can shorten them. An elaboration check rejects any per-digit refresh rate outside 25 Hz to 1 kHz.

Top module: `display_counter4`

## Requirements
- R1: The count runs from 0000 to 9999 and is stored as four BCD digits. No digit ever holds a value above 9.
- R2: The units digit advances by one every COUNT_DIV = CLK_HZ/COUNT_HZ clock cycles. The first step comes COUNT_DIV rising edges after reset is released. The default is 50 MHz / 2 Hz.
- R3: A digit at 9 that receives a step returns to 0 and steps the next digit. On the next slow tick, 9999 becomes 0000.
- R4: The scan index advances every SCAN_DIV = CLK_HZ/SCAN_HZ cycles in the order 0,1,2,3,0. Index 0 is the units digit and index 3 is the thousands digit. The first advance comes SCAN_DIV edges after reset is released.
- R5: The digit-select output dig_n is active low. Exactly one bit is low at any time, and bit i is low while digit i is shown.
- R6: The segment outputs are active high, with seg[0]=a through seg[6]=g, and seg[7] (the decimal point) is always 0. The patterns in hex for the digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: The segment outputs always show the pattern of the digit whose select is low. Segments and select change on the same clock edge.
- R8: Synchronous reset clears all digits to 0, the scan index to 0 and both dividers. While reset is held, the outputs are seg=3F and dig_n=1110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| seg | output | 8 | Segment lines a..g in bits 0..6, decimal point in bit 7 |
| dig_n | output | DIGITS | Active-low digit select, bit 0 is units |

## Verification
After reset is released, the count outputs change on the rising edge that completes every COUNT_DIV-th cycle. The selected digit changes on the edge that completes every SCAN_DIV-th cycle. In both cases the result is visible right after that edge, because the segment and select outputs are decoded from registers with no further delay. The bench numbers each rising edge after release and pushes that edge's expected select and segment values into a queue. A monitor pops each entry at the following falling edge, so every comparison samples between edges. A full wrap past 9999 and a reset in the middle of a run are both covered by the same edge-numbered model.

// File: rtl/disp_cnt_pkg.sv
package disp_cnt_pkg;

   // Active-high segment pattern, bit 0 = a ... bit 6 = g
   function automatic logic [6:0] bcd_to_seg(input logic [3:0] v);
      logic [6:0] p;
      case (v)
         4'd0:    p = 7'h3F;
         4'd1:    p = 7'h06;
         4'd2:    p = 7'h5B;
         4'd3:    p = 7'h4F;
         4'd4:    p = 7'h66;
         4'd5:    p = 7'h6D;
         4'd6:    p = 7'h7D;
         4'd7:    p = 7'h07;
         4'd8:    p = 7'h7F;
         4'd9:    p = 7'h6F;
         default: p = 7'h00;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
   parameter int DIV = 25_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   // R2
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R8
   div_clear_chk: assert property (@(posedge clk)
      rst |=> !tick);

endmodule

// File: rtl/bcd_digit.sv
module bcd_digit (
   input  logic       clk,
   input  logic       rst,
   input  logic       inc,
   output logic [3:0] value,
   output logic       carry
);
   always_ff @(posedge clk) begin
      if (rst)                    value <= 4'd0;
      else if (inc && value == 4'd9) value <= 4'd0;
      else if (inc)               value <= value + 4'd1;
   end

   assign carry = inc && (value == 4'd9);

   // R1
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      value <= 4'd9);

   // R3
   digit_roll_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && value == 4'd9) |=> value == 4'd0);

   // R2
   digit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && value < 4'd9) |=> value == $past(value) + 4'd1);

   // R8
   digit_clear_chk: assert property (@(posedge clk)
      rst |=> value == 4'd0);

endmodule

// File: rtl/digit_scan.sv
module digit_scan
   import disp_cnt_pkg::*;
#(
   parameter int DIGITS     = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step,
   input  logic [4*DIGITS-1:0]   digits_flat,
   output logic [7:0]            seg,
   output logic [DIGITS-1:0]     dig_sel
);
   localparam int IW = (DIGITS > 2) ? $clog2(DIGITS) : 1;
   localparam logic [IW-1:0] LAST = IW'(DIGITS - 1);

   logic [IW-1:0]     idx;
   logic [DIGITS-1:0] sel_hi;
   logic [3:0]        cur;

   always_ff @(posedge clk) begin
      if (rst)               idx <= '0;
      else if (step)         idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   for (genvar i = 0; i < DIGITS; i++) begin : g_sel
      assign sel_hi[i] = (idx == IW'(i));
   end

   if (ACTIVE_LOW) begin : g_low
      assign dig_sel = ~sel_hi;
   end else begin : g_high
      assign dig_sel = sel_hi;
   end

   always_comb cur = digits_flat[4*int'(idx) +: 4];

   assign seg = {1'b0, bcd_to_seg(cur)};

   // R5
   sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot(sel_hi));

   // R4
   scan_advance_chk: assert property (@(posedge clk) disable iff (rst)
      (step && idx != LAST) |=> idx == $past(idx) + 1'b1);

   // R4
   scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (step && idx == LAST) |=> idx == '0);

   // R7
   scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(idx));

endmodule

// File: rtl/display_counter4.sv
module display_counter4 #(
   parameter int CLK_HZ     = 50_000_000,
   parameter int COUNT_HZ   = 2,
   parameter int SCAN_HZ    = 500,
   parameter int DIGITS     = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [7:0]        seg,
   output logic [DIGITS-1:0] dig_n
);
   localparam int COUNT_DIV = CLK_HZ / COUNT_HZ;
   localparam int SCAN_DIV  = CLK_HZ / SCAN_HZ;
   localparam int REFRESH   = SCAN_HZ / DIGITS;

   if (DIGITS < 2) begin : g_bad_digits
      $error("DIGITS must be at least 2");
   end
   if (COUNT_DIV < 2 || SCAN_DIV < 2) begin : g_bad_div
      $error("divide ratios must be at least 2");
   end
   if (REFRESH < 25 || REFRESH > 1000) begin : g_bad_refresh
      $error("per-digit refresh must lie in 25..1000 Hz");
   end

   logic                count_tick;
   logic                scan_tick;
   logic [DIGITS:0]     dig_inc;
   logic [4*DIGITS-1:0] digits_flat;

   tick_div #(.DIV(COUNT_DIV)) u_count_div (
      .clk  (clk),
      .rst  (rst),
      .tick (count_tick)
   );

   tick_div #(.DIV(SCAN_DIV)) u_scan_div (
      .clk  (clk),
      .rst  (rst),
      .tick (scan_tick)
   );

   assign dig_inc[0] = count_tick;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      bcd_digit u_digit (
         .clk   (clk),
         .rst   (rst),
         .inc   (dig_inc[i]),
         .value (digits_flat[4*i +: 4]),
         .carry (dig_inc[i+1])
      );
   end

   digit_scan #(.DIGITS(DIGITS), .ACTIVE_LOW(ACTIVE_LOW)) u_scan (
      .clk         (clk),
      .rst         (rst),
      .step        (scan_tick),
      .digits_flat (digits_flat),
      .seg         (seg),
      .dig_sel     (dig_n)
   );

   // R3
   full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (count_tick && digits_flat == {DIGITS{4'd9}}) |=> digits_flat == '0);

   // R6
   dp_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(scan_tick) |-> seg[7] == 1'b0);

endmodule

// File: tb/display_counter4_test.sv
module display_counter4_test;
   localparam int CD = 10;   // 400 / 40
   localparam int SD = 2;    // 400 / 200
   localparam int ND = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] seg;
   logic [3:0] dig_n;

   always #5 clk = ~clk;

   display_counter4 #(.CLK_HZ(400), .COUNT_HZ(40), .SCAN_HZ(200)) uut (
      .clk   (clk),
      .rst   (rst),
      .seg   (seg),
      .dig_n (dig_n)
   );

   typedef struct {
      logic [7:0] seg;
      logic [3:0] dig;
      string      tag;
   } exp_t;

   exp_t sb[$];
   exp_t cur_e;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   function automatic logic [6:0] ref_seg(int d);
      case (d)
         0: return 7'h3F;
         1: return 7'h06;
         2: return 7'h5B;
         3: return 7'h4F;
         4: return 7'h66;
         5: return 7'h6D;
         6: return 7'h7D;
         7: return 7'h07;
         8: return 7'h7F;
         default: return 7'h6F;
      endcase
   endfunction

   // driver: expected outputs after n rising edges since reset release
   task automatic push_expect(int n, string tag);
      exp_t e;
      int c   = (n / CD) % 10000;
      int idx = (n / SD) % ND;
      int p   = 1;
      for (int k = 0; k < idx; k++) p = p * 10;
      e.seg = {1'b0, ref_seg((c / p) % 10)};
      e.dig = ~(4'b0001 << idx);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur_e = sb.pop_front();
         checks++;
         if (dig_n !== cur_e.dig) begin
            errors++;
            $display("FAIL R5 (%s) dig_n actual=%b expected=%b", cur_e.tag, dig_n, cur_e.dig);
         end
         checks++;
         if (seg !== cur_e.seg) begin
            errors++;
            $display("FAIL R6/R7 (%s) seg actual=%h expected=%h", cur_e.tag, seg, cur_e.seg);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      push_expect(0, "R8 reset state");
      @(negedge clk);
      rst <= 1'b0;
      for (int n = 1; n <= CD*10000 + 37; n++) begin
         @(posedge clk);
         if (((n / CD) % 10000) == 9999 || n >= CD*10000)
            push_expect(n, "R1/R3 wrap");
         else if (n % CD == 0)
            push_expect(n, "R2 units step");
         else
            push_expect(n, "R4/R5 scan");
      end
      @(negedge clk);
      rst <= 1'b1;
      @(posedge clk);
      push_expect(0, "R8 mid-run reset");
      @(posedge clk);
      push_expect(0, "R8 reset held");
      @(negedge clk);
      rst <= 1'b0;
      for (int n = 1; n <= 3*CD + 5; n++) begin
         @(posedge clk);
         push_expect(n, "R8 restart");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule